// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns word reads from a bus into read frames on a serial NOR flash, so that the flash content appears as read-only memory. Each accepted request starts one frame: chip select drops, an opcode and an address go out on one lane, optional dummy clocks follow, then four data bytes come back on one, two or four lanes. The four bytes form a 32-bit little-endian response. Chip select rises again after the last data clock.

The frame shape comes from a packed 32-bit setup word, one word per chip select. The word holds the opcode, the address length, the dummy byte count, an extra dummy bit count and the data lane mode. The top address bits pick the chip select and its setup word. The low bits give the byte offset inside the flash. A memory-map enable input hands the flash pins to this engine. While the enable is low, a request gets an immediate error response and the flash pins stay quiet.

Top module: `sfm_read_engine`

## Requirements
- R1: After reset, every `cs_no` bit is 1, `sclk_o` is 0, `io_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R2: A request accepted while `map_en_i` is 0 gets `rsp_valid_o`=1 and `rsp_err_o`=1 with `rsp_data_o`=0 in the cycle after acceptance. No chip select drops and no SCLK edge occurs.
- R3: The opcode in setup bits 7:0 is sent first, MSB first, on `io_o[0]`. `io_oe_o` equals 4'b0001 during the opcode and address clocks and 0 at all other times. Setup bits 23:16 have no effect on the frame.
- R4: The address has (setup bits 9:8)+1 bytes. It carries the low bits of the zero-extended offset, sent MSB first on `io_o[0]`.
- R5: The dummy clock count is 8 × setup bits 11:10 plus setup bits 28:24. A count of zero skips the dummy phase. No output driver is enabled during dummy clocks.
- R6: Setup bits 13:12 select the data lanes:
  - 0 (or 2): one lane, input on `io_i[1]`.
  - 1: two lanes, `io_i[1:0]`, with `io_i[1]` as the more significant bit.
  - 3: four lanes, `io_i[3:0]`, with `io_i[3]` as the most significant bit.
- R7: The data phase lasts 32/lanes clocks. Each byte arrives MSB first. The first byte received lands in `rsp_data_o[7:0]` and the fourth in `rsp_data_o[31:24]`.
- R8: The top CS_W bits of `req_addr_i` select the chip select and its setup word (slot i at `setup_i[32*i +: 32]`). At most one `cs_no` bit is low at any time.
- R9: `sclk_o` is low whenever no chip select is active. Each SCLK period is two `clk_i` cycles: low, then high. Input bits are sampled at the end of the high half.
- R10: Chip select rises right after the last data clock. `rsp_valid_o` is high for exactly that one cycle with `rsp_err_o`=0. `rsp_data_o` is 0 whenever `rsp_valid_o` is 0.
- R11: `map_en_i` is sampled only at acceptance. `req_ready_o` is low from acceptance through the response cycle. A change of `map_en_i` during a frame does not alter or abort it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_en_i | input | 1 | Memory-map enable: flash pins owned by this engine |
| setup_i | input | 32*NUM_CS | Packed setup word per chip select |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Engine can accept a request |
| req_addr_i | input | OFS_W+CS_W | Chip select index (top bits) and byte offset |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Request refused because mapping was disabled |
| rsp_data_o | output | 32 | Read word, little-endian |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | NUM_CS | Chip selects, active low |
| io_o | output | 4 | Serial data outputs |
| io_oe_o | output | 4 | Output enables for io lines |
| io_i | input | 4 | Serial data inputs |

## Verification
A wrong phase counter or a bad setup decode shows up as a wrong count of SCLK rising edges inside the chip select window. The bench counts those edges at the pins, so the error is seen by the end of the same frame. A lane or ordering fault scrambles the returned word, which is compared in the single cycle the response is valid. A stuck state appears as `req_ready_o` staying low, or as a missing response, and the next request then times out.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned SETUP_W = 32;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE
  } st_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [5:0] addr_beats;
    logic [5:0] dummy_beats;
    logic [2:0] lane_w;
    logic [5:0] data_beats;
  } seq_t;

  function automatic seq_t decode_setup(input logic [SETUP_W-1:0] w);
    seq_t s;
    s.opcode      = w[7:0];
    s.addr_beats  = 6'(({4'd0, w[9:8]} + 6'd1) << 3);
    s.dummy_beats = 6'({1'b0, w[11:10], 3'd0}) + 6'({1'b0, w[28:24]});
    unique case (w[13:12])
      2'd1:    begin s.lane_w = 3'd2; s.data_beats = 6'd16; end
      2'd3:    begin s.lane_w = 3'd4; s.data_beats = 6'd8;  end
      default: begin s.lane_w = 3'd1; s.data_beats = 6'd32; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sfm_seq_decode.sv
module sfm_seq_decode import sfm_pkg::*; #(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned CS_W   = 1
) (
  input  logic [NUM_CS*SETUP_W-1:0] setup_i,
  input  logic [CS_W-1:0]           cs_idx_i,
  output seq_t                      seq_o,
  output logic [NUM_CS-1:0]         cs_sel_o
);
  logic [SETUP_W-1:0] word;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    assign cs_sel_o[i] = (cs_idx_i == CS_W'(i));
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_sel_o[i]) word = word | setup_i[i*SETUP_W +: SETUP_W];
    end
    seq_o = decode_setup(word);
  end
endmodule

// File: rtl/sfm_tx_shift.sv
module sfm_tx_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/sfm_rx_pack.sv
module sfm_rx_pack #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned W = 8 * BYTES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic [2:0]   lane_w_i,
  input  logic [3:0]   io_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) begin
      unique case (lane_w_i)
        3'd4:    sr_q <= {sr_q[W-5:0], io_i};
        3'd2:    sr_q <= {sr_q[W-3:0], io_i[1:0]};
        default: sr_q <= {sr_q[W-2:0], io_i[1]};
      endcase
    end
  end

  // first byte shifted in ends up in the top byte: reverse to little-endian
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign word_o[8*b +: 8] = sr_q[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/sfm_read_engine.sv
module sfm_read_engine import sfm_pkg::*; #(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned OFS_W  = 24,
  localparam int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned ADDR_W = OFS_W + CS_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      map_en_i,
  input  logic [NUM_CS*SETUP_W-1:0] setup_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_err_o,
  output logic [31:0]               rsp_data_o,
  output logic                      sclk_o,
  output logic [NUM_CS-1:0]         cs_no,
  output logic [3:0]                io_o,
  output logic [3:0]                io_oe_o,
  input  logic [3:0]                io_i
);
  st_e               st_q;
  logic              ph_q;
  logic [5:0]        cnt_q;
  seq_t              seq_q, seq_d;
  logic [31:0]       ofs_q;
  logic              sclk_q, err_q;
  logic [NUM_CS-1:0] cs_n_q, cs_sel;
  logic              tx_bit, tx_load, tx_shift;
  logic [31:0]       tx_val, rx_word;
  logic              accept, active, beat_end, last_beat, rx_shift;

  sfm_seq_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
    .setup_i  (setup_i),
    .cs_idx_i (req_addr_i[ADDR_W-1 -: CS_W]),
    .seq_o    (seq_d),
    .cs_sel_o (cs_sel)
  );

  assign accept    = req_valid_i & req_ready_o;
  assign active    = (st_q == ST_CMD) | (st_q == ST_ADDR) | (st_q == ST_DUMMY) | (st_q == ST_DATA);
  assign beat_end  = active & ph_q;
  assign last_beat = beat_end & (cnt_q == 6'd0);

  assign tx_load  = (accept & map_en_i) | (last_beat & (st_q == ST_CMD));
  assign tx_shift = beat_end & ~tx_load;
  assign tx_val   = (st_q == ST_IDLE) ? {seq_d.opcode, 24'd0}
                                      : (ofs_q << (6'd32 - seq_q.addr_beats));
  assign rx_shift = beat_end & (st_q == ST_DATA);

  sfm_tx_shift #(.W(32)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_load),
    .load_val_i (tx_val),
    .shift_i    (tx_shift),
    .bit_o      (tx_bit)
  );

  sfm_rx_pack #(.BYTES(WORD_BYTES)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (rx_shift),
    .lane_w_i (seq_q.lane_w),
    .io_i     (io_i),
    .word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      seq_q  <= '0;
      ofs_q  <= '0;
      sclk_q <= 1'b0;
      err_q  <= 1'b0;
      cs_n_q <= '1;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (map_en_i) begin
              st_q   <= ST_CMD;
              ph_q   <= 1'b0;
              cnt_q  <= 6'd7;
              seq_q  <= seq_d;
              ofs_q  <= 32'(req_addr_i[OFS_W-1:0]);
              cs_n_q <= ~cs_sel;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: begin
          if (!ph_q) begin
            sclk_q <= 1'b1;
            ph_q   <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            ph_q   <= 1'b0;
            if (cnt_q != 6'd0) begin
              cnt_q <= cnt_q - 6'd1;
            end else begin
              unique case (st_q)
                ST_CMD: begin
                  st_q  <= ST_ADDR;
                  cnt_q <= seq_q.addr_beats - 6'd1;
                end
                ST_ADDR: begin
                  if (seq_q.dummy_beats != 6'd0) begin
                    st_q  <= ST_DUMMY;
                    cnt_q <= seq_q.dummy_beats - 6'd1;
                  end else begin
                    st_q  <= ST_DATA;
                    cnt_q <= seq_q.data_beats - 6'd1;
                  end
                end
                ST_DUMMY: begin
                  st_q  <= ST_DATA;
                  cnt_q <= seq_q.data_beats - 6'd1;
                end
                default: begin
                  st_q   <= ST_DONE;
                  cs_n_q <= '1;
                end
              endcase
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE) & ~err_q;
  assign rsp_valid_o = (st_q == ST_DONE) | err_q;
  assign rsp_err_o   = err_q;
  assign rsp_data_o  = (st_q == ST_DONE) ? rx_word : 32'd0;
  assign sclk_o      = sclk_q;
  assign cs_no       = cs_n_q;
  assign io_oe_o     = ((st_q == ST_CMD) | (st_q == ST_ADDR)) ? 4'b0001 : 4'b0000;
  assign io_o        = {3'b000, tx_bit & io_oe_o[0]};
endmodule

// File: rtl/sfm_read_engine_chk.sv
module sfm_read_engine_chk #(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned OFS_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              map_en_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [31:0]       rsp_data_o,
  input logic              sclk_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic [3:0]        io_oe_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1); // R8

  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (&cs_no && !sclk_o)); // R2

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> $past(req_valid_i && !map_en_i)); // R2

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_no |-> !sclk_o); // R9

  AST_OE_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_no |-> (io_oe_o == 4'b0000)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R10

  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_data_o == 32'd0)); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |-> !req_ready_o); // R11

  AST_RSP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R11
endmodule

bind sfm_read_engine sfm_read_engine_chk #(.NUM_CS(NUM_CS), .OFS_W(OFS_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .map_en_i    (map_en_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_data_o  (rsp_data_o),
  .sclk_o      (sclk_o),
  .cs_no       (cs_no),
  .io_oe_o     (io_oe_o)
);

// File: tb/sfm_read_engine_tb_top.sv
`timescale 1ns/1ps
module sfm_read_engine_tb_top;
  localparam int NCS = 2;
  localparam int OW  = 24;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            map_en = 1'b0;
  logic [NCS*32-1:0] setup = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [OW:0]     req_addr = '0;
  logic            rsp_valid, rsp_err;
  logic [31:0]     rsp_data;
  logic            sclk;
  logic [NCS-1:0]  cs_n;
  logic [3:0]      io_o, io_oe;
  logic [3:0]      io_i = 4'h0;

  always #5 clk = ~clk;

  sfm_read_engine #(.NUM_CS(NCS), .OFS_W(OW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .map_en_i(map_en), .setup_i(setup),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .sclk_o(sclk), .cs_no(cs_n), .io_o(io_o), .io_oe_o(io_oe), .io_i(io_i)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int cs, input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'(cs * 8'h3C);
  endfunction

  // flash model
  wire        cs_all = &cs_n;
  int         rise_cnt = 0, k_out = 0, cs_frames = 0, last_rises = 0, cur_cs = -1;
  int         m_abits = 24, m_pre = 32, m_lanes = 1;
  logic [7:0] op_cap = '0;
  logic [31:0] addr_cap = '0;
  bit         oe_bad = 0;
  int         act_cycles = 0;

  always @(negedge cs_all) begin
    rise_cnt = 0; k_out = 0; op_cap = '0; addr_cap = '0; oe_bad = 0;
    cs_frames++;
    cur_cs = -1;
    for (int i = 0; i < NCS; i++) if (!cs_n[i]) cur_cs = i;
  end

  always @(posedge cs_all) last_rises = rise_cnt;

  always @(posedge sclk) if (!cs_all) begin
    if (rise_cnt < 8) op_cap = {op_cap[6:0], io_o[0]};
    else if (rise_cnt < 8 + m_abits) addr_cap = {addr_cap[30:0], io_o[0]};
    if (rise_cnt < 8 + m_abits) begin
      if (io_oe != 4'b0001) oe_bad = 1;
    end else if (io_oe != 4'b0000) oe_bad = 1;
    rise_cnt++;
  end

  always @(negedge sclk) if (!cs_all && rise_cnt >= m_pre) begin
    int bp;
    logic [7:0] b, v;
    bp = k_out * m_lanes;
    b  = mem_byte(cur_cs, addr_cap + 32'(bp / 8));
    v  = (b >> (8 - (bp % 8) - m_lanes)) & 8'((1 << m_lanes) - 1);
    case (m_lanes)
      4: io_i = v[3:0];
      2: io_i = {2'b00, v[1:0]};
      default: io_i = {2'b00, v[0], 1'b0};
    endcase
    k_out++;
  end

  always @(negedge clk) if (!cs_all) act_cycles++;

  task automatic t_reset;
    chk(&cs_n === 1'b1, "R1 cs", 64'(cs_n), 64'(2'b11));
    chk(sclk === 1'b0, "R1 sclk", 64'(sclk), 0);
    chk(io_oe === 4'b0, "R1 oe", 64'(io_oe), 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
  endtask

  task automatic t_err(input logic [31:0] ofs);
    int f0;
    f0 = cs_frames;
    map_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {1'b0, ofs[OW-1:0]};
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R2 rsp_valid", 64'(rsp_valid), 1);
    chk(rsp_err === 1'b1, "R2 rsp_err", 64'(rsp_err), 1);
    chk(rsp_data === 32'd0, "R2 rsp_data", 64'(rsp_data), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 pulse", 64'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R2 ready back", 64'(req_ready), 1);
    chk(cs_frames == f0, "R2 no frame", 64'(cs_frames), 64'(f0));
    map_en = 1'b1;
  endtask

  task automatic t_read(input int cs, input logic [31:0] ofs, input logic [31:0] s,
                        input string tag, input bit drop_en);
    int nab, dmy, ln, exp_rises, wait_n;
    logic [31:0] ea, ew;
    bit prev_active;
    nab = (int'(s[9:8]) + 1) * 8;
    dmy = 8 * int'(s[11:10]) + int'(s[28:24]);
    ln  = (s[13:12] == 2'd1) ? 2 : (s[13:12] == 2'd3) ? 4 : 1;
    exp_rises = 8 + nab + dmy + 32 / ln;
    ea = (nab == 32) ? {8'd0, ofs[OW-1:0]} : ({8'd0, ofs[OW-1:0]} & ((32'd1 << nab) - 1));
    ew = {mem_byte(cs, ea + 3), mem_byte(cs, ea + 2), mem_byte(cs, ea + 1), mem_byte(cs, ea)};
    setup = {NCS{~s}};
    setup[cs*32 +: 32] = s;
    m_abits = nab; m_pre = 8 + nab + dmy; m_lanes = ln;
    map_en = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {1'(cs), ofs[OW-1:0]};
    act_cycles = 0;
    @(negedge clk);
    req_valid = 1'b0;
    if (drop_en) map_en = 1'b0;
    chk(req_ready === 1'b0, {"R11 ready low ", tag}, 64'(req_ready), 0);
    wait_n = 0;
    prev_active = !cs_all;
    while (rsp_valid !== 1'b1 && wait_n < 2000) begin
      prev_active = !cs_all;
      @(negedge clk);
      wait_n++;
    end
    chk(rsp_valid === 1'b1, {"R10 response ", tag}, 64'(rsp_valid), 1);
    chk(rsp_err === 1'b0, {"R10 no err ", tag}, 64'(rsp_err), 0);
    chk(cs_all === 1'b1 && prev_active, {"R10 cs released ", tag}, 64'(cs_n), 64'(2'b11));
    chk(rsp_data === ew, {"R6 R7 data ", tag}, 64'(rsp_data), 64'(ew));
    chk(op_cap === s[7:0], {"R3 opcode ", tag}, 64'(op_cap), 64'(s[7:0]));
    chk(addr_cap === ea, {"R4 address ", tag}, 64'(addr_cap), 64'(ea));
    chk(last_rises == exp_rises, {"R5 clock count ", tag}, 64'(last_rises), 64'(exp_rises));
    chk(!oe_bad, {"R3 R5 drivers ", tag}, 64'(oe_bad), 0);
    chk(cur_cs == cs, {"R8 select ", tag}, 64'(cur_cs), 64'(cs));
    chk(act_cycles == 2 * exp_rises, {"R9 sclk period ", tag}, 64'(act_cycles), 64'(2 * exp_rises));
    @(negedge clk);
    chk(rsp_valid === 1'b0, {"R10 pulse ", tag}, 64'(rsp_valid), 0);
    chk(rsp_data === 32'd0, {"R10 data quiet ", tag}, 64'(rsp_data), 0);
    chk(req_ready === 1'b1, {"R11 ready again ", tag}, 64'(req_ready), 1);
    map_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_err(32'h000100);
    t_read(0, 32'h012345, 32'h0012_0203, "single 3B", 0);
    t_read(0, 32'h012345, 32'h00A5_0203, "R3 write op ignored", 0);
    t_read(0, 32'h0A0B0C, 32'h0012_060B, "fast dummy byte", 0);
    t_read(1, 32'h3210F0, 32'h0012_166B, "dual", 0);
    t_read(1, 32'h00ABCD, 32'h0412_366C, "quad dummy bits", 0);
    t_read(0, 32'hFEDCBA, 32'h0012_0313, "4B address", 0);
    t_read(0, 32'h000055, 32'h0012_2203, "R6 mode 2 single", 0);
    t_read(1, 32'h0000C7, 32'h0012_0003, "1B address", 0);
    t_read(0, 32'h111111, 32'h0312_0203, "R5 dummy bits only", 0);
    t_read(1, 32'h204060, 32'h0012_166B, "R11 switch drop", 1);
    t_err(32'h000200);
    t_read(1, 32'h7FFFFC, 32'h0012_3203, "quad no dummy", 0);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule